// File: doc/BRIEF.md
# Multi-Rate Row Refresh Scheduler with Approximate Rate Sets

This block decides, row by row, whether a small DRAM bank gets a refresh command in the current pass. Rows that keep their data for a long time are refreshed less often. Two Bloom filters record which rows belong to the shortest retention class (every base round, the 64 ms class) and which belong to the middle class (every second round, 128 ms). Any row that is in neither filter falls back to the long default of one refresh every four base rounds (256 ms). Software or a profiling engine inserts row addresses through a load port. A clear input empties both filters.

A walker visits each row once per base round and probes both filters with that row address. A 2-bit round index picks which classes are due in the current round. When a row is due, the walker offers a refresh command downstream with a valid/ready handshake. Two occupancy timers then model how long the accepted command holds the command bus and the bank. A single-cycle pulse marks the end of each round. A filter can report a false positive but never a false negative, so an error can only make a row refresh more often than it needs to.

Top module: `mrr_sched`

## Requirements
- R1: While reset is active and on release, `cmd_vld`, `bank_busy`, `bus_busy` and `round_done` are 0 and `round_idx` is 0. Both filters are empty.
- R2: A load with `ld_mid`=0 inserts `ld_row` into the fast filter, and `ld_mid`=1 inserts it into the middle filter. Insertion sets bits h_i(r) = (r XOR (r >> (i+1)) XOR 7*i) mod 2^IDX_W for i = 0..K_HASH-1. `flt_clr` empties both filters and wins over a load in the same cycle.
- R3: A probe hits only when all K_HASH bits of the row are set, so an inserted row always hits.
- R4: In a round with index n, a row is due if it hits the fast filter, or it hits the middle filter and bit 0 of n is 0, or n is 0. Over four consecutive rounds starting at n = 0, a row is therefore commanded 4, 2 or 1 times. A fast hit takes priority over a middle hit.
- R5: Rows are visited in ascending order 0 to 2^ROW_W-1, once per round. A row that is not due is passed in one cycle.
- R6: `cmd_vld` stays high with `cmd_row` unchanged until `cmd_rdy` is high. It is low in the cycle after acceptance.
- R7: An accepted command makes `bank_busy` high for BANK_CYC cycles and `bus_busy` high for BUS_CYC cycles, starting the next cycle. `cmd_vld` never rises while `bank_busy` is high. BUS_CYC ≤ BANK_CYC.
- R8: While `ld_vld` or `flt_clr` is high and no command is pending, the walker does not probe or advance, and no command is raised.
- R9: `round_done` is a one-cycle pulse in the cycle after the last row is passed. In that same cycle `round_idx` has advanced by one, modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_clr | input | 1 | Empty both filters |
| ld_vld | input | 1 | Insert `ld_row` into a filter this cycle |
| ld_mid | input | 1 | Target filter: 0 fast class, 1 middle class |
| ld_row | input | ROW_W | Row address to insert |
| cmd_vld | output | 1 | Refresh command offered |
| cmd_row | output | ROW_W | Row to refresh |
| cmd_rdy | input | 1 | Downstream accepts the command |
| bank_busy | output | 1 | Bank occupied by a refresh |
| bus_busy | output | 1 | Command bus occupied by a refresh |
| round_done | output | 1 | Pulse: a base round has finished |
| round_idx | output | 2 | Current round index |

## Verification
The schedule is first run with only a few fast and middle rows loaded and one row placed in both filters. The per-row command counts over four rounds then show whether the fast class, the middle class, the default class and the priority between the filters each hold. A second run throttles `cmd_rdy` with a pseudo-random pattern and inserts rows in a multi-cycle burst while the walker is active. This separates handshake holding and stall behaviour from the decision logic. A third run clears the filters and expects every row to be commanded exactly once, which shows the clear took effect. All outputs are also compared every cycle against a behavioural model.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  typedef enum logic {SC_SCAN, SC_ISSUE} scan_st_e;

  // XOR-folded hash index i of a row address, reduced to idx_w bits
  function automatic int unsigned hash_idx(int unsigned row, int unsigned i, int unsigned idx_w);
    int unsigned v;
    v = row ^ (row >> (i + 1)) ^ (7 * i);
    return v & ((32'd1 << idx_w) - 32'd1);
  endfunction

endpackage

// File: rtl/mrr_bloom.sv
module mrr_bloom #(
  parameter int ROW_W = 6,
  parameter int IDX_W = 5,
  parameter int K     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins,
  input  logic [ROW_W-1:0] ins_row,
  input  logic [ROW_W-1:0] probe_row,
  output logic             hit
);
  import mrr_pkg::*;

  localparam int BITS = 1 << IDX_W;

  logic [BITS-1:0]  arr_q, arr_d, ins_mask, prb_mask;
  logic [IDX_W-1:0] ins_idx, prb_idx;

  always_comb begin
    ins_mask = '0;
    prb_mask = '0;
    ins_idx  = '0;
    prb_idx  = '0;
    for (int i = 0; i < K; i++) begin
      ins_idx = IDX_W'(hash_idx(32'(ins_row), unsigned'(i), IDX_W));
      prb_idx = IDX_W'(hash_idx(32'(probe_row), unsigned'(i), IDX_W));
      ins_mask[ins_idx] = 1'b1;
      prb_mask[prb_idx] = 1'b1;
    end
    hit   = ((arr_q & prb_mask) == prb_mask);
    arr_d = arr_q;
    if (clr)      arr_d = '0;
    else if (ins) arr_d = arr_q | ins_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arr_q <= '0;
    else        arr_q <= arr_d;
  end

endmodule

// File: rtl/mrr_busy.sv
module mrr_busy #(
  parameter int CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = CW'(CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/mrr_scan.sv
module mrr_scan #(
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             hit_fast,
  input  logic             hit_mid,
  input  logic             bank_busy,
  input  logic             cmd_rdy,
  output logic [ROW_W-1:0] row,
  output logic             cmd_vld,
  output logic             fire,
  output logic             round_done,
  output logic [1:0]       rnd
);
  import mrr_pkg::*;

  scan_st_e         st_q, st_d;
  logic [ROW_W-1:0] ptr_q, ptr_d;
  logic [1:0]       rnd_q, rnd_d;
  logic             done_q, done_d;
  logic             due, adv, last;

  always_comb begin
    due   = hit_fast | (hit_mid & ~rnd_q[0]) | (rnd_q == 2'd0);
    last  = (ptr_q == '1);
    adv   = 1'b0;
    st_d  = st_q;
    case (st_q)
      SC_SCAN: begin
        if (!hold) begin
          if (!due)            adv  = 1'b1;
          else if (!bank_busy) st_d = SC_ISSUE;
        end
      end
      SC_ISSUE: begin
        if (cmd_rdy) begin
          st_d = SC_SCAN;
          adv  = 1'b1;
        end
      end
      default: st_d = SC_SCAN;
    endcase
    ptr_d  = adv ? ptr_q + 1'b1 : ptr_q;
    rnd_d  = (adv && last) ? rnd_q + 2'd1 : rnd_q;
    done_d = adv && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_SCAN;
      ptr_q  <= '0;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      rnd_q  <= rnd_d;
      done_q <= done_d;
    end
  end

  assign row        = ptr_q;
  assign cmd_vld    = (st_q == SC_ISSUE);
  assign fire       = cmd_vld & cmd_rdy;
  assign round_done = done_q;
  assign rnd        = rnd_q;

endmodule

// File: rtl/mrr_sched.sv
module mrr_sched #(
  parameter int ROW_W    = 6,
  parameter int IDX_W    = 5,
  parameter int K_HASH   = 3,
  parameter int BUS_CYC  = 1,
  parameter int BANK_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_clr,
  input  logic             ld_vld,
  input  logic             ld_mid,
  input  logic [ROW_W-1:0] ld_row,
  output logic             cmd_vld,
  output logic [ROW_W-1:0] cmd_row,
  input  logic             cmd_rdy,
  output logic             bank_busy,
  output logic             bus_busy,
  output logic             round_done,
  output logic [1:0]       round_idx
);
  logic             hold, fire;
  logic [1:0]       hits;
  logic [ROW_W-1:0] scan_row;

  assign hold = ld_vld | flt_clr;

  // index 0: fast class filter, index 1: middle class filter
  for (genvar g = 0; g < 2; g++) begin : g_flt
    mrr_bloom #(.ROW_W(ROW_W), .IDX_W(IDX_W), .K(K_HASH)) u_flt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (flt_clr),
      .ins       (ld_vld && (ld_mid == (g == 1))),
      .ins_row   (ld_row),
      .probe_row (scan_row),
      .hit       (hits[g])
    );
  end

  mrr_scan #(.ROW_W(ROW_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .hit_fast   (hits[0]),
    .hit_mid    (hits[1]),
    .bank_busy  (bank_busy),
    .cmd_rdy    (cmd_rdy),
    .row        (scan_row),
    .cmd_vld    (cmd_vld),
    .fire       (fire),
    .round_done (round_done),
    .rnd        (round_idx)
  );

  mrr_busy #(.CYC(BANK_CYC)) u_bank_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fire),
    .busy  (bank_busy)
  );

  mrr_busy #(.CYC(BUS_CYC)) u_bus_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fire),
    .busy  (bus_busy)
  );

  assign cmd_row = scan_row;

endmodule

// File: rtl/mrr_sched_chk.sv
module mrr_sched_chk #(
  parameter int ROW_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic [ROW_W-1:0] scan_row,
  input logic             cmd_vld,
  input logic             cmd_rdy,
  input logic [ROW_W-1:0] cmd_row,
  input logic             bank_busy,
  input logic             bus_busy,
  input logic             round_done,
  input logic [1:0]       round_idx
);

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && !cmd_rdy |=> cmd_vld && $stable(cmd_row));

  // R6
  cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_rdy |=> !cmd_vld);

  // R7
  no_issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> !bank_busy);

  // R7
  occupy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld && cmd_rdy |=> bank_busy && bus_busy);

  // R7
  bus_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> bank_busy);

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !cmd_vld |=> !cmd_vld && $stable(scan_row));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |=> !round_done);

  // R9
  round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |-> round_idx == $past(round_idx) + 2'd1);

endmodule

bind mrr_sched mrr_sched_chk #(.ROW_W(ROW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold       (hold),
  .scan_row   (scan_row),
  .cmd_vld    (cmd_vld),
  .cmd_rdy    (cmd_rdy),
  .cmd_row    (cmd_row),
  .bank_busy  (bank_busy),
  .bus_busy   (bus_busy),
  .round_done (round_done),
  .round_idx  (round_idx)
);

// File: tb/mrr_sched_tb.sv
module mrr_sched_tb;
  localparam int ROW_W = 6, IDX_W = 5, K = 3, BUS = 1, BANK = 5;
  localparam int ROWS = 1 << ROW_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flt_clr = 1'b0, ld_vld = 1'b0, ld_mid = 1'b0, cmd_rdy = 1'b1;
  logic [ROW_W-1:0] ld_row = '0;
  logic cmd_vld, bank_busy, bus_busy, round_done;
  logic [ROW_W-1:0] cmd_row;
  logic [1:0] round_idx;

  mrr_sched #(.ROW_W(ROW_W), .IDX_W(IDX_W), .K_HASH(K), .BUS_CYC(BUS), .BANK_CYC(BANK)) u_dut (
    .clk(clk), .rst_n(rst_n), .flt_clr(flt_clr), .ld_vld(ld_vld), .ld_mid(ld_mid),
    .ld_row(ld_row), .cmd_vld(cmd_vld), .cmd_row(cmd_row), .cmd_rdy(cmd_rdy),
    .bank_busy(bank_busy), .bus_busy(bus_busy), .round_done(round_done), .round_idx(round_idx));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done_run = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [31:0] fbv [2];
  int m_iss, m_ptr, m_rnd, m_bank, m_bus, m_done, m_hold;

  function automatic int hidx(int row, int i);
    return (row ^ (row >> (i + 1)) ^ (7 * i)) & ((1 << IDX_W) - 1);
  endfunction

  function automatic bit probe(int f, int row);
    for (int i = 0; i < K; i++) if (!fbv[f][hidx(row, i)]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_iss = 0; m_ptr = 0; m_rnd = 0; m_bank = 0; m_bus = 0; m_done = 0; m_hold = 0;
      fbv[0] = '0; fbv[1] = '0;
    end else begin : mdl
      bit due, adv, fire;
      due  = probe(0, m_ptr) || (probe(1, m_ptr) && (m_rnd % 2 == 0)) || (m_rnd == 0);
      fire = (m_iss != 0) && cmd_rdy;
      adv  = 0;
      if (m_iss != 0) begin
        if (cmd_rdy) begin m_iss = 0; adv = 1; end
      end else if (!(ld_vld || flt_clr)) begin
        if (!due) adv = 1;
        else if (m_bank == 0) m_iss = 1;
      end
      m_done = (adv && m_ptr == ROWS - 1) ? 1 : 0;
      if (adv) begin
        if (m_ptr == ROWS - 1) m_rnd = (m_rnd + 1) % 4;
        m_ptr = (m_ptr + 1) % ROWS;
      end
      if (fire) begin m_bank = BANK; m_bus = BUS; end
      else begin
        if (m_bank > 0) m_bank--;
        if (m_bus > 0) m_bus--;
      end
      m_hold = (ld_vld || flt_clr) ? 1 : 0;
      if (flt_clr) begin fbv[0] = '0; fbv[1] = '0; end
      else if (ld_vld) for (int i = 0; i < K; i++) fbv[ld_mid ? 1 : 0][hidx(int'(ld_row), i)] = 1'b1;
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk(cmd_vld == (m_iss != 0), m_hold ? "R8 cmd_vld during load" : "R4 cmd_vld", int'(cmd_vld), m_iss);
      if (cmd_vld) chk(int'(cmd_row) == m_ptr, "R6 cmd_row", int'(cmd_row), m_ptr);
      chk(bank_busy == (m_bank != 0), "R7 bank_busy", int'(bank_busy), int'(m_bank != 0));
      chk(bus_busy == (m_bus != 0), "R7 bus_busy", int'(bus_busy), int'(m_bus != 0));
      chk(round_done == (m_done != 0), "R9 round_done", int'(round_done), m_done);
      chk(int'(round_idx) == m_rnd, "R9 round_idx", int'(round_idx), m_rnd);
    end
  end

  // ready pattern and per-row command counting
  int rdy_mode = 0, c_st = 0, c_rounds = 0;
  int cnt [ROWS];
  logic [7:0] lf = 8'h5a;
  always @(negedge clk) begin
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    cmd_rdy = (rdy_mode != 0) ? lf[0] : 1'b1;
    if (c_st == 1 && round_done && round_idx == 2'd0) begin c_st = 2; c_rounds = 0; end
    else if (c_st == 2 && round_done) begin
      c_rounds++;
      if (c_rounds == 4) c_st = 3;
    end
    if (c_st == 2 && cmd_vld && cmd_rdy) cnt[int'(cmd_row)]++;
  end

  task automatic load(bit mid, int row);
    ld_vld = 1'b1; ld_mid = mid; ld_row = ROW_W'(row);
    @(negedge clk);
    ld_vld = 1'b0;
  endtask

  task automatic count_rounds(string tag, bit only_ones);
    for (int r = 0; r < ROWS; r++) cnt[r] = 0;
    c_st = 1;
    while (c_st != 3) @(negedge clk);
    c_st = 0;
    for (int r = 0; r < ROWS; r++) begin : rowchk
      int exp;
      exp = only_ones ? 1 : (probe(0, r) ? 4 : (probe(1, r) ? 2 : 1));
      chk(cnt[r] == exp, tag, cnt[r], exp);
    end
  endtask

  task automatic finish_run();
    done_run = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_vld == 1'b0, "R1 cmd_vld in reset", int'(cmd_vld), 0);
    chk(bank_busy == 1'b0 && bus_busy == 1'b0, "R1 busy in reset", int'(bank_busy), 0);
    chk(round_done == 1'b0, "R1 round_done in reset", int'(round_done), 0);
    chk(round_idx == 2'd0, "R1 round_idx in reset", int'(round_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // phase 1: R2 loads while the walker runs, 17 goes into both filters
    load(0, 5); load(0, 17); load(0, 40);
    load(1, 9); load(1, 33); load(1, 62); load(1, 17);
    chk(probe(0, 17) && probe(1, 9), "R3 inserted rows hit", 0, 1);
    count_rounds("R4 per-row commands over four rounds (R3 R5)", 1'b0);
    // phase 2: throttled ready, multi-cycle load burst
    rdy_mode = 1;
    ld_vld = 1'b1; ld_mid = 1'b0; ld_row = 6'd50; @(negedge clk);
    ld_mid = 1'b1; ld_row = 6'd1; @(negedge clk);
    ld_mid = 1'b0; ld_row = 6'd63; @(negedge clk);
    ld_vld = 1'b0;
    count_rounds("R6 counts under throttled ready (R4)", 1'b0);
    // phase 3: clear filters, every row once per four rounds
    rdy_mode = 0;
    flt_clr = 1'b1; ld_vld = 1'b1; ld_row = 6'd7; @(negedge clk);
    flt_clr = 1'b0; ld_vld = 1'b0;
    count_rounds("R2 clear empties both filters", 1'b1);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule